// File: doc/BRIEF.md
# E1 Receive Loss-of-Signal Conditioner

This block sits behind the bipolar AMI receiver of a 2048 kbit/s E1 line. It takes the receiver's two unipolar rail signals and a one-cycle bit strobe derived from the recovered clock. It watches the line for a dead condition. Loss is declared after a long run of bit periods with no pulse on either rail. Loss is cleared once enough marks arrive inside a window two frames long.

Downstream logic, typically a framer, gets several outputs. It gets the two rails, which can be inverted and which are forced to a fixed level while loss is active. It gets the OR of both rails as a single return-to-zero data stream. It gets a loss indicator whose active level is selectable. All state advances only on the bit strobe, so the block can run from any system clock that is at least as fast as the bit rate.

Top module: `e1_los_cond`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block into the loss-active state. It clears all counters and the registered rail inputs, and it drives `rail_a_out`, `rail_b_out` and `data_out` low.
- R2: Each strobe registers the rail inputs, and the next strobe evaluates them. Loss is declared on the strobe that evaluates the 128th consecutive bit period with both rails low. The zero-run count stops at 128 and does not wrap.
- R3: Any evaluated bit period with either rail high (a mark) restarts the zero-run count. A run of 127 zeros, then a mark, then 128 zeros therefore leaves the block out of loss.
- R4: While loss is active, marks are counted inside a 512-bit window. The window runs freely from reset, and each window boundary clears the mark count. Loss clears on the strobe that evaluates the 64th mark of one window. With 63 marks in one window and the rest of the marks in the next window, loss does not clear until the next window holds 64 marks.
- R5: `data_out` is the registered OR of the two rails. It appears one strobe after the rails are sampled. `inv_n` never affects it, nor does the loss state.
- R6: Outside loss, `inv_n` low inverts both rail outputs. `inv_n` high passes them through unchanged.
- R7: While loss is active, both rail outputs are forced high if `inv_n` is low, and forced low if `inv_n` is high.
- R8: With `ind_pol_n` high, `los_ind` is low during loss and high otherwise. With `ind_pol_n` low, this polarity is reversed.
- R9: The registered outputs change only on cycles where `bit_en` is high. Each rail output reflects the sample taken on the previous strobe, which is a fixed latency of one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe per recovered bit period |
| rail_a_in | input | 1 | Positive-pulse rail from the line receiver |
| rail_b_in | input | 1 | Negative-pulse rail from the line receiver |
| inv_n | input | 1 | Rail inversion select, low inverts |
| ind_pol_n | input | 1 | Loss indicator polarity select, low inverts |
| rail_a_out | output | 1 | Conditioned positive rail |
| rail_b_out | output | 1 | Conditioned negative rail |
| data_out | output | 1 | OR of both rails, return-to-zero |
| los_ind | output | 1 | Loss indicator, level set by `ind_pol_n` |

## Verification
A corrupted zero-run count shows up at `los_ind`. Loss is then declared one strobe early or late, or never declared after a long silent run. The edge tests at 127 and 128 zeros expose this in the same strobe. A wrong mark count or window phase shows as recovery at the wrong strobe: either before the 64th mark, or across a window boundary where it should wait. A broken loss flag or output register shows on the rails at the next strobe: forcing fails to apply, or the inversion is applied to the wrong state, while `data_out` still carries the line data.

// File: rtl/e1_los_cond.sv
module e1_los_cond #(
  parameter int LOSS_RUN     = 128,
  parameter int MARKS_NEEDED = 64,
  parameter int WINDOW_BITS  = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rail_a_in,
  input  logic rail_b_in,
  input  logic inv_n,
  input  logic ind_pol_n,
  output logic rail_a_out,
  output logic rail_b_out,
  output logic data_out,
  output logic los_ind
);
  localparam int ZW = $clog2(LOSS_RUN + 1);
  localparam int MW = $clog2(MARKS_NEEDED + 1);
  localparam int WW = $clog2(WINDOW_BITS);

  logic          a_q, b_q, lost_q;
  logic [ZW-1:0] zcnt;
  logic [MW-1:0] mcnt;
  logic [WW-1:0] wcnt;

  wire mark      = a_q | b_q;
  wire win_end   = wcnt == WW'(WINDOW_BITS - 1);
  wire declare   = !lost_q && !mark && zcnt == ZW'(LOSS_RUN - 1);
  wire recover   = lost_q && mark && mcnt == MW'(MARKS_NEEDED - 1);
  wire lost_d    = declare ? 1'b1 : (recover ? 1'b0 : lost_q);
  wire force_lvl = ~inv_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q        <= 1'b0;
      b_q        <= 1'b0;
      lost_q     <= 1'b1;
      zcnt       <= '0;
      mcnt       <= '0;
      wcnt       <= '0;
      rail_a_out <= 1'b0;
      rail_b_out <= 1'b0;
      data_out   <= 1'b0;
    end else if (bit_en) begin
      a_q    <= rail_a_in;
      b_q    <= rail_b_in;
      lost_q <= lost_d;
      wcnt   <= win_end ? '0 : wcnt + 1'b1;
      if (mark)
        zcnt <= '0;
      else if (zcnt != ZW'(LOSS_RUN))
        zcnt <= zcnt + 1'b1;
      if (!lost_d || win_end)
        mcnt <= '0;
      else if (mark)
        mcnt <= mcnt + 1'b1;
      rail_a_out <= lost_d ? force_lvl : (a_q ^ force_lvl);
      rail_b_out <= lost_d ? force_lvl : (b_q ^ force_lvl);
      data_out   <= mark;
    end
  end

  assign los_ind = ind_pol_n ? ~lost_q : lost_q;
endmodule

// File: rtl/e1_los_cond_chk.sv
module e1_los_cond_chk #(
  parameter int LOSS_RUN     = 128,
  parameter int MARKS_NEEDED = 64,
  parameter int ZW = 8,
  parameter int MW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          inv_n,
  input logic          rail_a_out,
  input logic          rail_b_out,
  input logic          data_out,
  input logic          lost_q,
  input logic          mark,
  input logic [ZW-1:0] zcnt,
  input logic [MW-1:0] mcnt
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    int'(zcnt) <= LOSS_RUN);

  assert_declare_at_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_q) && !$past(rst) |-> int'($past(zcnt)) == LOSS_RUN - 1);

  assert_mark_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    $past(bit_en) && $past(mark) && !$past(rst) |-> zcnt == '0);

  assert_recover_count_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(lost_q) && !$past(rst) |-> int'($past(mcnt)) == MARKS_NEEDED - 1);

  assert_forced_rails_R7: assert property (@(posedge clk) disable iff (rst)
    $past(bit_en) && !$past(rst) && lost_q && $stable(inv_n)
      |-> rail_a_out == !inv_n && rail_b_out == !inv_n);

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) && !$past(rst)
      |-> $stable(rail_a_out) && $stable(rail_b_out) && $stable(data_out));
endmodule

bind e1_los_cond e1_los_cond_chk #(
  .LOSS_RUN(LOSS_RUN), .MARKS_NEEDED(MARKS_NEEDED), .ZW(ZW), .MW(MW)
) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .inv_n(inv_n),
  .rail_a_out(rail_a_out), .rail_b_out(rail_b_out), .data_out(data_out),
  .lost_q(lost_q), .mark(mark), .zcnt(zcnt), .mcnt(mcnt)
);

// File: tb/test_e1_los_cond.sv
module test_e1_los_cond;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic ra = 1'b0, rb = 1'b0, inv_n = 1'b1, pol_n = 1'b1;
  logic oa, ob, od, los;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {a, b, inv_n, pol_n, exp_a, exp_b, exp_data, exp_los} while out of loss
  localparam logic [7:0] VEC [8] = '{
    8'b1011_1011, 8'b0111_0111, 8'b1001_0111, 8'b0100_1010,
    8'b1110_1110, 8'b1101_0011, 8'b0011_0001, 8'b0000_1100
  };

  always #(PERIOD/2) clk = ~clk;

  e1_los_cond i_e1_los_cond (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rail_a_in(ra), .rail_b_in(rb),
    .inv_n(inv_n), .ind_pol_n(pol_n), .rail_a_out(oa), .rail_b_out(ob),
    .data_out(od), .los_ind(los)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic strobe(input logic a, input logic b);
    @(negedge clk);
    ra = a; rb = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // with pol_n high, los low means loss active
  task automatic chk_lost(input string req, input logic exp_lost);
    chk(req, {3'b0, los}, {3'b0, ~exp_lost});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset outputs", {oa, ob, od, los}, 4'b0000);

    strobe(1'b1, 1'b0);
    chk("R9 one-strobe latency", {1'b0, oa, ob, od}, 4'b0000);
    strobe(1'b0, 1'b0);
    chk("R5 R7 forced low, data passes", {1'b0, oa, ob, od}, 4'b0001);
    inv_n = 1'b0;
    @(negedge clk);
    chk("R9 no change without strobe", {1'b0, oa, ob, od}, 4'b0001);
    strobe(1'b0, 1'b0);
    chk("R7 forced high", {1'b0, oa, ob, od}, 4'b0110);
    inv_n = 1'b1;

    // R4 window: 63 marks in window one, 64 in window two
    do_reset();
    for (int s = 1; s <= 511; s++) strobe(s <= 63, 1'b0);
    chk_lost("R4 63 marks insufficient", 1'b1);
    for (int s = 512; s <= 575; s++) strobe(1'b1, 1'b0);
    chk_lost("R4 63 marks in new window", 1'b1);
    strobe(1'b0, 1'b1);
    chk_lost("R4 recovery at 64th mark", 1'b0);
    strobe(1'b1, 1'b0);

    for (int i = 0; i < 8; i++) begin
      inv_n = VEC[i][5];
      pol_n = VEC[i][4];
      strobe(VEC[i][7], VEC[i][6]);
      strobe(VEC[i][7], VEC[i][6]);
      chk($sformatf("R5 R6 R8 vector %0d", i), {oa, ob, od, los}, VEC[i][3:0]);
    end
    inv_n = 1'b1;
    pol_n = 1'b1;

    // R3: 127 zeros, mark, 128 zeros stays out of loss; one more declares (R2)
    strobe(1'b1, 1'b0);
    for (int s = 0; s < 127; s++) strobe(1'b0, 1'b0);
    strobe(1'b0, 1'b1);
    for (int s = 0; s < 128; s++) strobe(1'b0, 1'b0);
    chk_lost("R3 mark restarts zero run", 1'b0);
    strobe(1'b0, 1'b0);
    chk_lost("R2 loss at 128th zero", 1'b1);
    chk("R7 forced low in loss", {2'b0, oa, ob}, 4'b0000);
    pol_n = 1'b0;
    #1;
    chk("R8 inverted indicator", {3'b0, los}, 4'b0001);
    pol_n = 1'b1;
    for (int s = 0; s < 300; s++) strobe(1'b0, 1'b0);
    chk_lost("R2 saturated count stays in loss", 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule